// File: doc/BRIEF.md
# Scenario Jump Controller

This block decides which stored scenario the playback engine runs next, and in which cycle the change happens. Each scenario is described by a start pointer and a length in words, kept in a descriptor table. A request to change scenario carries a handle, which is an index into that table. The handle comes from one of two sources. In internal mode, a jump request reads the next entry of an on-chip play table. In dynamic mode, the play table is bypassed and the handle is taken from a 16-bit parallel input, qualified by a data-valid strobe.

An accepted handle becomes pending. Three timing policies decide when a pending handle commits:
- **Immediate**: the handle commits after a fixed latency counted in clocks.
- **End of waveform**: the handle commits at the next waveform boundary reported by the engine.
- **End of scenario**: the handle commits when the current scenario finishes. If the words left to play at capture time are fewer than the immediate latency, the current scenario plays one more full time before the jump.

When a scenario ends with nothing to commit, the advance mode applies:
- **Continuous**: the scenario restarts.
- **Single**: the block raises a hold flag, keeps the last start pointer, and waits for a trigger.

Every change of scenario is signalled to the engine by a one-cycle load pulse together with the start pointer.

Top module: `scen_jump_ctrl`

## Requirements
- R1: After reset, `load_o`, `playing_o`, `hold_o` and `err_o` are 0, and `cur_handle_o` and `start_ptr_o` are 0.
- R2: A trigger while idle or holding starts the current scenario (handle 0 after reset). `load_o` pulses for one cycle, two clock edges after the edge that samples `trig_i`, with the start pointer of that scenario. `playing_o` is then 1.
- R3: With `cont_i`=0, the scenario ends on the tick that consumes its last word. If no jump commits at that point, `hold_o` becomes 1, `playing_o` becomes 0 and `start_ptr_o` stays unchanged. A later trigger reloads the scenario and clears `hold_o`.
- R4: With `cont_i`=1, a scenario end with no commit reloads the same start pointer and `hold_o` stays 0.
- R5: In dynamic mode (`dyn_mode_i`=1), a handle is captured only on the first cycle that `ext_valid_i` is high; keeping it high captures nothing more. Each source is ignored while the other mode is selected: `jump_req_i` in dynamic mode, `ext_valid_i` in internal mode.
- R6: Jump mode 0 (immediate): the new scenario's `load_o` appears JUMP_LAT+2 edges after the edge that captures the handle.
- R7: Jump mode 1 (end of waveform): a pending handle commits when `wfm_end_i` is sampled while playing, with `load_o` two edges later. Without a boundary, nothing loads.
- R8: Jump mode 2 (end of scenario): a handle captured with at least JUMP_LAT words left commits on the final word of the current scenario, with `load_o` two edges after that tick.
- R9: In jump mode 2, a handle captured with fewer than JUMP_LAT words left makes the current scenario reload once more. The jump then occurs at the end of that repeat.
- R10: A newly captured handle replaces one that is still pending; only the newest one commits.
- R11: A handle not below `scen_count_i` is ignored, loads nothing, and sets `err_o`. `err_o` stays 1 until reset.
- R12: In internal mode, each jump request takes the next play-table entry in address order. The read pointer wraps to entry 0 after `hm_len_i` entries.
- R13: When a capture and a commit fall in the same cycle, the old pending handle commits. The new handle stays pending for the following commit.
- R14: A trigger while a scenario is playing has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dyn_mode_i | input | 1 | 1 selects the external handle input; 0 selects the play table |
| jmode_i | input | 2 | Jump timing: 0 immediate, 1 end of waveform, 2 or 3 end of scenario |
| cont_i | input | 1 | 1 continuous advance, 0 single advance |
| trig_i | input | 1 | Start or restart while idle or holding |
| jump_req_i | input | 1 | Internal mode: fetch the next play-table handle |
| ext_handle_i | input | HANDLE_W | External scenario handle |
| ext_valid_i | input | 1 | External handle valid strobe |
| hm_we_i | input | 1 | Play-table write enable |
| hm_waddr_i | input | clog2(HM_DEPTH) | Play-table write address |
| hm_wdata_i | input | HANDLE_W | Play-table write data |
| hm_len_i | input | clog2(HM_DEPTH)+1 | Number of used play-table entries |
| sc_we_i | input | 1 | Descriptor write enable |
| sc_waddr_i | input | clog2(NUM_SCEN) | Descriptor write address (handle) |
| sc_wstart_i | input | PTR_W | Descriptor start pointer |
| sc_wlen_i | input | LEN_W | Descriptor length in words |
| scen_count_i | input | HANDLE_W | Number of loaded scenarios |
| word_tick_i | input | 1 | Engine consumed one word |
| wfm_end_i | input | 1 | Engine reached a waveform boundary |
| start_ptr_o | output | PTR_W | Start pointer of the scenario being loaded |
| load_o | output | 1 | One-cycle load strobe for the engine |
| cur_handle_o | output | HANDLE_W | Handle of the last loaded scenario |
| playing_o | output | 1 | A scenario is playing |
| hold_o | output | 1 | Single mode finished; waiting for a trigger |
| err_o | output | 1 | Sticky invalid-handle flag |

## Verification
The riskiest case is a new handle capture that lands in the same cycle as a commit of the handle already pending. The bench provokes it by raising `ext_valid_i` in the same cycle as a waveform boundary, while an earlier handle is pending. It then requires the first load to carry the earlier scenario's pointer, and the next boundary to load the newer one. A related coincidence, capturing a handle near the end of a scenario, is driven with few words left so that the extra repeat occurs before the jump.

// File: rtl/scen_jump_pkg.sv
package scen_jump_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_PLAY  = 2'd2,
    ST_HOLD  = 2'd3
  } sj_state_e;

  localparam logic [1:0] JM_IMMEDIATE = 2'd0;
  localparam logic [1:0] JM_WAVE_END  = 2'd1;

endpackage

// File: rtl/scen_desc_ram.sv
module scen_desc_ram #(
  parameter int NUM_SCEN = 256,
  parameter int HANDLE_W = 16,
  parameter int PTR_W    = 24,
  parameter int LEN_W    = 16,
  localparam int AW      = $clog2(NUM_SCEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [PTR_W-1:0]    wstart,
  input  logic [LEN_W-1:0]    wlen,
  input  logic                req,
  input  logic [HANDLE_W-1:0] req_handle,
  output logic                rd_valid,
  output logic [PTR_W-1:0]    rd_start,
  output logic [LEN_W-1:0]    rd_len,
  output logic [HANDLE_W-1:0] rd_handle
);

  localparam int DW = PTR_W + LEN_W;

  logic [DW-1:0] desc_mem [NUM_SCEN];
  logic [DW-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (we) desc_mem[waddr] <= {wstart, wlen};
    if (req) begin
      rd_word   <= desc_mem[req_handle[AW-1:0]];
      rd_handle <= req_handle;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= req;
  end

  assign rd_start = rd_word[DW-1:LEN_W];
  assign rd_len   = rd_word[LEN_W-1:0];

  p_fetch_answers_r2: assert property (@(posedge clk) disable iff (rst)
    req |=> rd_valid);

endmodule

// File: rtl/scen_play_table.sv
module scen_play_table #(
  parameter int HM_DEPTH = 64,
  parameter int HANDLE_W = 16,
  localparam int AW      = $clog2(HM_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [HANDLE_W-1:0] wdata,
  input  logic [AW:0]         used_len,
  input  logic                req,
  output logic                out_valid,
  output logic [HANDLE_W-1:0] out_handle
);

  logic [HANDLE_W-1:0] tbl_mem [HM_DEPTH];
  logic [AW-1:0]       rptr;
  logic [AW:0]         rptr_inc;
  logic                take;

  assign take     = req && (used_len != '0);
  assign rptr_inc = {1'b0, rptr} + 1'b1;

  always_ff @(posedge clk) begin
    if (we)   tbl_mem[waddr] <= wdata;
    if (take) out_handle <= tbl_mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) rptr <= (rptr_inc >= used_len) ? '0 : rptr_inc[AW-1:0];
    end
  end

  p_table_answers_r12: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

endmodule

// File: rtl/scen_jump_ctrl.sv
module scen_jump_ctrl
  import scen_jump_pkg::*;
#(
  parameter int NUM_SCEN = 256,
  parameter int HM_DEPTH = 64,
  parameter int HANDLE_W = 16,
  parameter int PTR_W    = 24,
  parameter int LEN_W    = 16,
  parameter int JUMP_LAT = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          dyn_mode_i,
  input  logic [1:0]                    jmode_i,
  input  logic                          cont_i,
  input  logic                          trig_i,
  input  logic                          jump_req_i,
  input  logic [HANDLE_W-1:0]           ext_handle_i,
  input  logic                          ext_valid_i,
  input  logic                          hm_we_i,
  input  logic [$clog2(HM_DEPTH)-1:0]   hm_waddr_i,
  input  logic [HANDLE_W-1:0]           hm_wdata_i,
  input  logic [$clog2(HM_DEPTH):0]     hm_len_i,
  input  logic                          sc_we_i,
  input  logic [$clog2(NUM_SCEN)-1:0]   sc_waddr_i,
  input  logic [PTR_W-1:0]              sc_wstart_i,
  input  logic [LEN_W-1:0]              sc_wlen_i,
  input  logic [HANDLE_W-1:0]           scen_count_i,
  input  logic                          word_tick_i,
  input  logic                          wfm_end_i,
  output logic [PTR_W-1:0]              start_ptr_o,
  output logic                          load_o,
  output logic [HANDLE_W-1:0]           cur_handle_o,
  output logic                          playing_o,
  output logic                          hold_o,
  output logic                          err_o
);

  localparam int                  CNT_W    = $clog2(JUMP_LAT + 1);
  localparam logic [CNT_W-1:0]    CNT_INIT = CNT_W'(JUMP_LAT - 1);
  localparam logic [LEN_W-1:0]    LAT_WORDS = LEN_W'(JUMP_LAT);
  localparam logic [HANDLE_W:0]   SCEN_LIM = (HANDLE_W + 1)'(NUM_SCEN);

  sj_state_e            state;
  logic                 ext_q;
  logic                 pend_v, pend_extra;
  logic [HANDLE_W-1:0]  pend_h, cur_h;
  logic [CNT_W-1:0]     imm_cnt;
  logic [LEN_W-1:0]     rem;

  logic                 tbl_v;
  logic [HANDLE_W-1:0]  tbl_h;
  logic                 src_v;
  logic [HANDLE_W-1:0]  src_h;
  logic                 src_ok, capture, bad;

  logic                 in_play, eos, commit_now, extra_rep, trig_start;
  logic                 take_pend, launch, goes_hold;
  logic [HANDLE_W-1:0]  launch_h;

  logic                 rd_valid;
  logic [PTR_W-1:0]     rd_start;
  logic [LEN_W-1:0]     rd_len;
  logic [HANDLE_W-1:0]  rd_handle;

  scen_play_table #(
    .HM_DEPTH (HM_DEPTH),
    .HANDLE_W (HANDLE_W)
  ) u_table (
    .clk        (clk),
    .rst        (rst),
    .we         (hm_we_i),
    .waddr      (hm_waddr_i),
    .wdata      (hm_wdata_i),
    .used_len   (hm_len_i),
    .req        (jump_req_i && !dyn_mode_i),
    .out_valid  (tbl_v),
    .out_handle (tbl_h)
  );

  scen_desc_ram #(
    .NUM_SCEN (NUM_SCEN),
    .HANDLE_W (HANDLE_W),
    .PTR_W    (PTR_W),
    .LEN_W    (LEN_W)
  ) u_desc (
    .clk        (clk),
    .rst        (rst),
    .we         (sc_we_i),
    .waddr      (sc_waddr_i),
    .wstart     (sc_wstart_i),
    .wlen       (sc_wlen_i),
    .req        (launch),
    .req_handle (launch_h),
    .rd_valid   (rd_valid),
    .rd_start   (rd_start),
    .rd_len     (rd_len),
    .rd_handle  (rd_handle)
  );

  // handle source selection and validation
  always_comb begin
    if (dyn_mode_i) begin
      src_v = ext_valid_i && !ext_q;
      src_h = ext_handle_i;
    end else begin
      src_v = tbl_v;
      src_h = tbl_h;
    end
    src_ok  = (src_h < scen_count_i) && ({1'b0, src_h} < SCEN_LIM);
    capture = src_v && src_ok;
    bad     = src_v && !src_ok;
  end

  // commit / advance decisions
  always_comb begin
    in_play    = (state == ST_PLAY);
    eos        = in_play && word_tick_i && (rem == LEN_W'(1));
    trig_start = trig_i && ((state == ST_IDLE) || (state == ST_HOLD));
    commit_now = 1'b0;
    if (pend_v && in_play) begin
      if (jmode_i == JM_IMMEDIATE)     commit_now = (imm_cnt == '0);
      else if (jmode_i == JM_WAVE_END) commit_now = wfm_end_i || eos;
      else                             commit_now = eos && !pend_extra;
    end
    extra_rep = pend_v && eos && pend_extra && !commit_now && (jmode_i[1] == 1'b1);
    take_pend = commit_now || (trig_start && pend_v);
    launch    = take_pend || trig_start || (eos && (cont_i || extra_rep));
    goes_hold = eos && !take_pend && !extra_rep && !cont_i;
    launch_h  = take_pend ? pend_h : cur_h;
  end

  assign playing_o = in_play;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ext_q        <= 1'b0;
      pend_v       <= 1'b0;
      pend_h       <= '0;
      pend_extra   <= 1'b0;
      imm_cnt      <= '0;
      cur_h        <= '0;
      rem          <= '0;
      err_o        <= 1'b0;
      load_o       <= 1'b0;
      start_ptr_o  <= '0;
      cur_handle_o <= '0;
      hold_o       <= 1'b0;
    end else begin
      ext_q  <= ext_valid_i;
      load_o <= 1'b0;
      if (bad) err_o <= 1'b1;

      // pending handle bookkeeping: a fresh capture always wins the slot
      if (capture) begin
        pend_v     <= 1'b1;
        pend_h     <= src_h;
        imm_cnt    <= CNT_INIT;
        pend_extra <= in_play && (jmode_i[1] == 1'b1) && (rem < LAT_WORDS) && !eos;
      end else if (take_pend) begin
        pend_v     <= 1'b0;
        pend_extra <= 1'b0;
      end else begin
        if (extra_rep) pend_extra <= 1'b0;
        if (pend_v && imm_cnt != '0) imm_cnt <= imm_cnt - 1'b1;
      end

      if (launch) begin
        state  <= ST_FETCH;
        cur_h  <= launch_h;
        hold_o <= 1'b0;
      end else if (goes_hold) begin
        state  <= ST_HOLD;
        hold_o <= 1'b1;
      end else if (state == ST_FETCH && rd_valid) begin
        state <= ST_PLAY;
      end

      if (state == ST_FETCH && rd_valid) begin
        load_o       <= 1'b1;
        start_ptr_o  <= rd_start;
        cur_handle_o <= rd_handle;
        rem          <= rd_len;
      end else if (in_play && word_tick_i && rem != '0) begin
        rem <= rem - 1'b1;
      end
    end
  end

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  p_load_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o);

  p_hold_keeps_ptr_r3: assert property (@(posedge clk) disable iff (rst)
    (hold_o && $past(hold_o)) |-> $stable(start_ptr_o));

  p_cont_never_holds_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_o) |-> !$past(cont_i));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    imm_cnt <= CNT_INIT);

endmodule

// File: tb/scen_jump_ctrl_tb.sv
module scen_jump_ctrl_tb;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dyn_mode_i = 0, cont_i = 0, trig_i = 0, jump_req_i = 0;
  logic [1:0]  jmode_i = 0;
  logic [15:0] ext_handle_i = 0;
  logic        ext_valid_i = 0;
  logic        hm_we_i = 0;
  logic [5:0]  hm_waddr_i = 0;
  logic [15:0] hm_wdata_i = 0;
  logic [6:0]  hm_len_i = 7'd3;
  logic        sc_we_i = 0;
  logic [7:0]  sc_waddr_i = 0;
  logic [23:0] sc_wstart_i = 0;
  logic [15:0] sc_wlen_i = 0;
  logic [15:0] scen_count_i = 16'd4;
  logic        word_tick_i = 0, wfm_end_i = 0;
  logic [23:0] start_ptr_o;
  logic        load_o, playing_o, hold_o, err_o;
  logic [15:0] cur_handle_o;

  int total = 0, bad = 0, cyc = 0, load_cnt = 0, load_cyc = 0;
  logic [23:0] last_ptr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scen_jump_ctrl #(.NUM_SCEN(256), .HM_DEPTH(64), .HANDLE_W(16), .PTR_W(24),
                   .LEN_W(16), .JUMP_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .dyn_mode_i(dyn_mode_i), .jmode_i(jmode_i),
    .cont_i(cont_i), .trig_i(trig_i), .jump_req_i(jump_req_i),
    .ext_handle_i(ext_handle_i), .ext_valid_i(ext_valid_i),
    .hm_we_i(hm_we_i), .hm_waddr_i(hm_waddr_i), .hm_wdata_i(hm_wdata_i),
    .hm_len_i(hm_len_i), .sc_we_i(sc_we_i), .sc_waddr_i(sc_waddr_i),
    .sc_wstart_i(sc_wstart_i), .sc_wlen_i(sc_wlen_i),
    .scen_count_i(scen_count_i), .word_tick_i(word_tick_i),
    .wfm_end_i(wfm_end_i), .start_ptr_o(start_ptr_o), .load_o(load_o),
    .cur_handle_o(cur_handle_o), .playing_o(playing_o), .hold_o(hold_o),
    .err_o(err_o));

  // load monitor, sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (load_o) begin
      load_cnt = load_cnt + 1;
      load_cyc = cyc;
      last_ptr = start_ptr_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    trig_i = 0; jump_req_i = 0; ext_valid_i = 0; word_tick_i = 0; wfm_end_i = 0;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic start_play();
    trig_i = 1'b1;
    step(1);
    trig_i = 1'b0;
    step(1);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      word_tick_i = 1'b1;
      step(1);
    end
    word_tick_i = 1'b0;
  endtask

  task automatic ext_send(input logic [15:0] h);
    ext_handle_i = h;
    ext_valid_i  = 1'b1;
    step(1);
    ext_valid_i  = 1'b0;
    step(1);
  endtask

  task automatic wave_end();
    wfm_end_i = 1'b1;
    step(1);
    wfm_end_i = 1'b0;
    step(1);
  endtask

  task automatic configure();
    logic [23:0] starts [4];
    logic [15:0] lens [4];
    logic [15:0] plays [3];
    starts = '{24'h100, 24'h200, 24'h300, 24'h400};
    lens   = '{16'd8, 16'd20, 16'd6, 16'd3};
    plays  = '{16'd2, 16'd1, 16'd3};
    for (int i = 0; i < 4; i++) begin
      sc_we_i = 1; sc_waddr_i = 8'(i); sc_wstart_i = starts[i]; sc_wlen_i = lens[i];
      step(1);
    end
    sc_we_i = 0;
    for (int i = 0; i < 3; i++) begin
      hm_we_i = 1; hm_waddr_i = 6'(i); hm_wdata_i = plays[i];
      step(1);
    end
    hm_we_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 load", 32'(load_o), 0);
    chk("R1 playing", 32'(playing_o), 0);
    chk("R1 hold", 32'(hold_o), 0);
    chk("R1 err", 32'(err_o), 0);
    chk("R1 handle", 32'(cur_handle_o), 0);
    chk("R1 ptr", 32'(start_ptr_o), 0);
  endtask

  task automatic t_single();
    int c0, n;
    do_reset();
    dyn_mode_i = 0; jmode_i = 2'd1; cont_i = 0;
    c0 = cyc;
    start_play();
    chk("R2 start latency", 32'(load_cyc - c0), 2);
    chk("R2 start ptr", 32'(last_ptr), 32'h100);
    chk("R2 playing", 32'(playing_o), 1);
    n = load_cnt;
    trig_i = 1; step(1); trig_i = 0; step(3);
    chk("R14 trig in play loads", 32'(load_cnt), 32'(n));
    ticks(8);
    step(1);
    chk("R3 hold", 32'(hold_o), 1);
    chk("R3 not playing", 32'(playing_o), 0);
    chk("R3 ptr kept", 32'(start_ptr_o), 32'h100);
    chk("R3 no reload", 32'(load_cnt), 32'(n));
    start_play();
    chk("R3 retrigger reload", 32'(load_cnt), 32'(n + 1));
    chk("R3 hold cleared", 32'(hold_o), 0);
  endtask

  task automatic t_cont();
    int n;
    do_reset();
    dyn_mode_i = 0; jmode_i = 2'd1; cont_i = 1;
    start_play();
    n = load_cnt;
    ticks(8);
    step(1);
    chk("R4 reload count", 32'(load_cnt), 32'(n + 1));
    chk("R4 reload ptr", 32'(last_ptr), 32'h100);
    chk("R4 no hold", 32'(hold_o), 0);
  endtask

  task automatic t_imm();
    int c0, n;
    do_reset();
    dyn_mode_i = 1; jmode_i = 2'd0; cont_i = 1;
    start_play();
    n = load_cnt;
    ext_handle_i = 16'd2;
    ext_valid_i = 1;
    c0 = cyc;
    step(12);
    chk("R6 immediate latency", 32'(load_cyc - c0), 32'(LAT + 2));
    chk("R6 immediate ptr", 32'(last_ptr), 32'h300);
    chk("R6 handle", 32'(cur_handle_o), 2);
    chk("R5 single capture", 32'(load_cnt), 32'(n + 1));
    jump_req_i = 1; step(1); jump_req_i = 0; step(10);
    chk("R5 jump_req ignored in dynamic", 32'(load_cnt), 32'(n + 1));
    ext_valid_i = 0;
    step(1);
    dyn_mode_i = 0;
    ext_send(16'd1);
    step(10);
    chk("R5 ext ignored in internal", 32'(load_cnt), 32'(n + 1));
  endtask

  task automatic t_eow();
    int c0, n;
    do_reset();
    dyn_mode_i = 1; jmode_i = 2'd1; cont_i = 1;
    start_play();
    n = load_cnt;
    ext_send(16'd1);
    step(2);
    ext_send(16'd3);
    step(2);
    chk("R7 no boundary no load", 32'(load_cnt), 32'(n));
    c0 = cyc;
    wave_end();
    chk("R7 boundary latency", 32'(load_cyc - c0), 2);
    chk("R10 newest ptr", 32'(last_ptr), 32'h400);
    chk("R10 newest handle", 32'(cur_handle_o), 3);
    chk("R10 one load", 32'(load_cnt), 32'(n + 1));
  endtask

  task automatic t_eos();
    int n;
    do_reset();
    dyn_mode_i = 1; jmode_i = 2'd2; cont_i = 1;
    start_play();
    n = load_cnt;
    ext_send(16'd2);
    ticks(7);
    chk("R8 no early jump", 32'(load_cnt), 32'(n));
    ticks(1);
    step(1);
    chk("R8 jump at end", 32'(load_cnt), 32'(n + 1));
    chk("R8 jump ptr", 32'(last_ptr), 32'h300);
  endtask

  task automatic t_extra();
    int n;
    do_reset();
    dyn_mode_i = 1; jmode_i = 2'd2; cont_i = 1;
    start_play();
    n = load_cnt;
    ticks(6);
    ext_send(16'd2);
    ticks(2);
    step(1);
    chk("R9 extra repeat count", 32'(load_cnt), 32'(n + 1));
    chk("R9 extra repeat ptr", 32'(last_ptr), 32'h100);
    ticks(8);
    step(1);
    chk("R9 jump after repeat", 32'(load_cnt), 32'(n + 2));
    chk("R9 jump ptr", 32'(last_ptr), 32'h300);
  endtask

  task automatic t_err();
    int n;
    do_reset();
    dyn_mode_i = 1; jmode_i = 2'd1; cont_i = 1;
    start_play();
    n = load_cnt;
    ext_send(16'd7);
    chk("R11 err set", 32'(err_o), 1);
    wave_end();
    chk("R11 invalid ignored", 32'(load_cnt), 32'(n));
    ext_send(16'd1);
    wave_end();
    chk("R11 valid after invalid", 32'(last_ptr), 32'h200);
    chk("R11 err sticky", 32'(err_o), 1);
  endtask

  task automatic t_internal();
    logic [23:0] exp_ptr [4];
    exp_ptr = '{24'h300, 24'h200, 24'h400, 24'h300};
    do_reset();
    dyn_mode_i = 0; jmode_i = 2'd1; cont_i = 1;
    start_play();
    for (int i = 0; i < 4; i++) begin
      jump_req_i = 1; step(1); jump_req_i = 0; step(2);
      wave_end();
      chk("R12 table order", 32'(last_ptr), 32'(exp_ptr[i]));
    end
  endtask

  task automatic t_overlap();
    int n;
    do_reset();
    dyn_mode_i = 1; jmode_i = 2'd1; cont_i = 1;
    start_play();
    n = load_cnt;
    ext_send(16'd1);
    ext_handle_i = 16'd2;
    ext_valid_i = 1;
    wfm_end_i = 1;
    step(1);
    ext_valid_i = 0;
    wfm_end_i = 0;
    step(1);
    chk("R13 old pending commits", 32'(last_ptr), 32'h200);
    chk("R13 old handle", 32'(cur_handle_o), 1);
    step(1);
    wave_end();
    chk("R13 new pending next", 32'(last_ptr), 32'h300);
    chk("R13 load count", 32'(load_cnt), 32'(n + 2));
  endtask

  initial begin
    do_reset();
    t_reset();
    configure();
    t_single();
    t_cont();
    t_imm();
    t_eow();
    t_eos();
    t_extra();
    t_err();
    t_internal();
    t_overlap();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule